// File: doc/BRIEF.md
# Two-Wire Bus Slave with Guarded Register Map

This block is a two-wire serial bus slave that serves an 80-byte register space, clocked by a fast system clock that oversamples the bus lines. Sixteen control and status bytes sit at 0x80 to 0x8F. A 64-row table follows at 0x90 to 0xCF. A master reaches the map with ordinary write transactions: a slave address, one word-address byte, then data bytes. It reads the map in combined format: a write of the word address, a repeated START, then a read with streaming output.

Writes are guarded in three ways. A volatile write-enable latch must be set first. A write-protect pin, when low, refuses every write except a write to the latch. Three single-byte registers refuse any data byte that follows theirs in the same transaction. Table writes wrap inside a 16-row page. When a STOP closes a transaction that changed persistent bytes, the slave goes deaf for a programmable number of clock cycles. During that window it does not acknowledge even its own address, so a master can poll for completion.

Top module: `twi_regmap_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal 1010 followed by `dev_sel_i[2:0]`. Bit 0 selects a read when it is 1. After a mismatch it ignores the bus and acknowledges nothing until the next START.
- R2: While the write-enable latch is 0, a data byte is not acknowledged and is discarded, unless its target is 0x86. The slave then waits for the next START.
- R3: Writing 0x80 to 0x86 sets the latch, writing 0x00 clears it, and any other value is acknowledged but leaves it unchanged. The latch resets to 0. A read of 0x86 returns the latch in bit 7 and 0 in bits 6..0.
- R4: After a data byte addressed to 0x80, 0x85 or 0x86 has been accepted, the next data byte of the same transaction is not acknowledged and has no effect.
- R5: In a table write, the low four address bits step and wrap inside the 16-row page. Twelve bytes written from 0x9B fill 0x9B..0x9F and then 0x90..0x96. A 20-byte write overwrites the first four rows of the page.
- R6: A STOP that ends a transaction that stored into 0x80, 0x85 or the table starts a busy window of `BUSY_CYCLES` clocks. Inside it the slave acknowledges nothing, not even its address, and leaves SDA released. After the window it acknowledges again.
- R7: With `wp_n_i` low, every data byte is refused without acknowledge, except one addressed to 0x86.
- R8: A read streams bytes MSB first from the word address, and the pointer increments by one per byte, also across 0x8F to 0x90. Output continues while the master acknowledges. A master NACK ends output, and the slave leaves SDA released until the next START.
- R9: Writes to 0x82, 0x84 and 0x87..0x8F are acknowledged but change nothing, and these bytes read as 0x00. Addresses below 0x80 or above 0xCF read as 0xFF, and writes to them have no effect.
- R10: After reset SDA is released, 0x80 reads 0x08, 0x85 reads 0x03, and every other control byte and table row reads 0x00.
- R11: Writes only to the volatile bytes 0x81, 0x83 and 0x86, or to unmapped addresses, start no busy window. 0x81 keeps only its low six bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| dev_sel_i | input | 3 | Device-select bits matched against address bits 3..1 |
| wp_n_i | input | 1 | Write-protect pin, low refuses writes except to the latch |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The table is swept in full. Four page writes carry a per-row arithmetic pattern, and one 64-byte streaming read checks it. This tells correct row decoding apart from aliasing and off-by-one pointers. Page writes that start mid-page, and a page write longer than 16 bytes, separate wrap-within-page from a plain linear increment. Acknowledge patterns are tried against every guard combination: latch clear, latch set, protect pin low, single-byte registers, wrong address and the busy window. The observed acknowledge bit shows which guard decided. Read-back after each refused byte shows that the refused byte changed no state.

// File: rtl/twi_pkg.sv
package twi_pkg;

    // Fixed device-type nibble in the address byte
    localparam logic [3:0] DEV_TYPE   = 4'b1010;

    // Map locations whose behaviour differs
    localparam logic [7:0] A_CFG0     = 8'h80;
    localparam logic [7:0] A_SEL      = 8'h81;
    localparam logic [7:0] A_DIRECT   = 8'h83;
    localparam logic [7:0] A_CFG5     = 8'h85;
    localparam logic [7:0] A_LATCH    = 8'h86;
    localparam logic [7:0] A_CTL_LAST = 8'h8F;
    localparam logic [7:0] A_TBL_BASE = 8'h90;

    localparam logic [7:0] LATCH_SET  = 8'h80;
    localparam logic [7:0] LATCH_CLR  = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_WADDR,
        PH_WDATA
    } byte_role_e;

    function automatic logic single_only(input logic [7:0] a);
        return (a == A_CFG0) || (a == A_CFG5) || (a == A_LATCH);
    endfunction

endpackage

// File: rtl/twi_bus_sync.sv
module twi_bus_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);

    typedef struct packed {
        logic [2:0] scl;
        logic [2:0] sda;
    } sy_t;

    sy_t q, d;

    always_comb begin
        d     = q;
        d.scl = {q.scl[1:0], scl_i};
        d.sda = {q.sda[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    // bit 1 is the synchronised level, bit 2 the level one clock earlier
    assign sda_o   = q.sda[1];
    assign rise_o  =  q.scl[1] & ~q.scl[2];
    assign fall_o  = ~q.scl[1] &  q.scl[2];
    assign start_o =  q.scl[1] &  q.scl[2] &  q.sda[2] & ~q.sda[1];
    assign stop_o  =  q.scl[1] &  q.scl[2] & ~q.sda[2] &  q.sda[1];

endmodule

// File: rtl/twi_regfile.sv
module twi_regfile import twi_pkg::*; #(
    parameter int          TBL_ROWS = 64,
    parameter logic [7:0]  CFG0_RST = 8'h08,
    parameter logic [7:0]  CFG5_RST = 8'h03
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en_i,
    input  logic [7:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [7:0] rd_addr_i,
    output logic [7:0] rd_data_o,
    output logic       wel_o
);

    localparam int         RW       = $clog2(TBL_ROWS);
    localparam logic [7:0] TBL_LAST = 8'(int'(A_TBL_BASE) + TBL_ROWS - 1);

    typedef struct packed {
        logic [7:0] cfg0;
        logic [5:0] sel;
        logic [7:0] direct;
        logic [7:0] cfg5;
        logic       wel;
    } ctl_t;

    ctl_t       ctl_q, ctl_d;
    logic [7:0] tbl_q [TBL_ROWS];
    logic [7:0] tbl_d [TBL_ROWS];

    function automatic logic in_table(input logic [7:0] a);
        return (a >= A_TBL_BASE) && (a <= TBL_LAST);
    endfunction

    always_comb begin
        ctl_d = ctl_q;
        for (int i = 0; i < TBL_ROWS; i++) tbl_d[i] = tbl_q[i];
        if (wr_en_i) begin
            case (wr_addr_i)
                A_CFG0:   ctl_d.cfg0   = wr_data_i;
                A_SEL:    ctl_d.sel    = wr_data_i[5:0];
                A_DIRECT: ctl_d.direct = wr_data_i;
                A_CFG5:   ctl_d.cfg5   = wr_data_i;
                A_LATCH: begin
                    if (wr_data_i == LATCH_SET)      ctl_d.wel = 1'b1;
                    else if (wr_data_i == LATCH_CLR) ctl_d.wel = 1'b0;
                end
                default: begin
                    if (in_table(wr_addr_i))
                        tbl_d[RW'(wr_addr_i - A_TBL_BASE)] = wr_data_i;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{cfg0: CFG0_RST, sel: '0, direct: '0, cfg5: CFG5_RST, wel: 1'b0};
            for (int i = 0; i < TBL_ROWS; i++) tbl_q[i] <= '0;
        end else begin
            ctl_q <= ctl_d;
            for (int i = 0; i < TBL_ROWS; i++) tbl_q[i] <= tbl_d[i];
        end
    end

    always_comb begin
        if (in_table(rd_addr_i)) begin
            rd_data_o = tbl_q[RW'(rd_addr_i - A_TBL_BASE)];
        end else if (rd_addr_i >= A_CFG0 && rd_addr_i <= A_CTL_LAST) begin
            case (rd_addr_i)
                A_CFG0:   rd_data_o = ctl_q.cfg0;
                A_SEL:    rd_data_o = {2'b00, ctl_q.sel};
                A_DIRECT: rd_data_o = ctl_q.direct;
                A_CFG5:   rd_data_o = ctl_q.cfg5;
                A_LATCH:  rd_data_o = {ctl_q.wel, 7'b0};
                default:  rd_data_o = 8'h00;
            endcase
        end else begin
            rd_data_o = 8'hFF;
        end
    end

    assign wel_o = ctl_q.wel;

endmodule

// File: rtl/twi_proto.sv
module twi_proto import twi_pkg::*; #(
    parameter int BUSY_CYCLES = 50000,
    parameter int TBL_ROWS    = 64,
    parameter int PAGE_BITS   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       rise_i,
    input  logic       fall_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_n_i,
    input  logic       wel_i,
    input  logic [7:0] rd_data_i,
    output logic [7:0] rd_addr_o,
    output logic       wr_en_o,
    output logic [7:0] wr_addr_o,
    output logic [7:0] wr_data_o,
    output logic       sda_oe_o,
    output logic       busy_o
);

    localparam int         BW       = $clog2(BUSY_CYCLES + 1);
    localparam logic [7:0] TBL_LAST = 8'(int'(A_TBL_BASE) + TBL_ROWS - 1);
    localparam logic [7:0] PMASK    = 8'((1 << PAGE_BITS) - 1);

    typedef struct packed {
        bus_state_e    state;
        byte_role_e    role;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [7:0]    ptr;
        logic          rnw;
        logic          drive;
        logic          locked;
        logic          dirty;
        logic          mack;
        logic [BW-1:0] busy_cnt;
    } st_t;

    st_t  q, d;
    logic busy, dev_ok, data_ok;

    function automatic logic in_table(input logic [7:0] a);
        return (a >= A_TBL_BASE) && (a <= TBL_LAST);
    endfunction

    function automatic logic persistent(input logic [7:0] a);
        return (a == A_CFG0) || (a == A_CFG5) || in_table(a);
    endfunction

    function automatic logic [7:0] step_wr(input logic [7:0] a);
        if (in_table(a)) return (a & ~PMASK) | ((a + 8'd1) & PMASK);
        return a + 8'd1;
    endfunction

    assign busy    = (q.busy_cnt != '0);
    assign dev_ok  = (q.sh[7:1] == {DEV_TYPE, dev_sel_i});
    assign data_ok = !q.locked && ((q.ptr == A_LATCH) || (wel_i && wp_n_i));

    always_comb begin
        d         = q;
        wr_en_o   = 1'b0;
        wr_addr_o = q.ptr;
        wr_data_o = q.sh;
        if (busy) begin
            d.busy_cnt = q.busy_cnt - BW'(1);
            d.state    = ST_IDLE;
            d.drive    = 1'b0;
        end else if (start_i) begin
            d.state  = ST_RX;
            d.role   = PH_DEV;
            d.cnt    = '0;
            d.drive  = 1'b0;
            d.locked = 1'b0;
        end else if (stop_i) begin
            d.state = ST_IDLE;
            d.drive = 1'b0;
            if (q.dirty) begin
                d.busy_cnt = BW'(BUSY_CYCLES);
                d.dirty    = 1'b0;
            end
        end else begin
            case (q.state)
                ST_RX: begin
                    if (rise_i && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_i && q.cnt == 4'd8) begin
                        d.state = ST_IDLE;
                        case (q.role)
                            PH_DEV: begin
                                if (dev_ok) begin
                                    d.state = ST_ACK;
                                    d.drive = 1'b1;
                                    d.rnw   = q.sh[0];
                                end
                            end
                            PH_WADDR: begin
                                d.ptr   = q.sh;
                                d.state = ST_ACK;
                                d.drive = 1'b1;
                            end
                            default: begin
                                if (data_ok) begin
                                    wr_en_o = 1'b1;
                                    d.state = ST_ACK;
                                    d.drive = 1'b1;
                                    d.ptr   = step_wr(q.ptr);
                                    if (single_only(q.ptr)) d.locked = 1'b1;
                                    if (persistent(q.ptr))  d.dirty  = 1'b1;
                                end
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall_i) begin
                        d.drive = 1'b0;
                        d.cnt   = '0;
                        case (q.role)
                            PH_DEV: begin
                                if (q.rnw) begin
                                    d.state = ST_TX;
                                    d.sh    = rd_data_i;
                                    d.drive = ~rd_data_i[7];
                                end else begin
                                    d.state = ST_RX;
                                    d.role  = PH_WADDR;
                                end
                            end
                            default: begin
                                d.state = ST_RX;
                                d.role  = PH_WDATA;
                            end
                        endcase
                    end
                end
                ST_TX: begin
                    if (rise_i && q.cnt < 4'd8) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_i && q.cnt == 4'd8) begin
                        d.drive = 1'b0;
                        d.state = ST_MACK;
                    end else if (fall_i && q.cnt != 4'd0) begin
                        d.sh    = {q.sh[6:0], 1'b0};
                        d.drive = ~q.sh[6];
                    end
                end
                ST_MACK: begin
                    if (rise_i) begin
                        d.mack = !sda_i;
                    end else if (fall_i) begin
                        d.ptr = q.ptr + 8'd1;
                        if (q.mack) begin
                            d.state = ST_TX;
                            d.cnt   = '0;
                            d.sh    = rd_data_i;
                            d.drive = ~rd_data_i[7];
                        end else begin
                            d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr_o = (q.state == ST_MACK) ? q.ptr + 8'd1 : q.ptr;
    assign sda_oe_o  = q.drive;
    assign busy_o    = busy;

endmodule

// File: rtl/twi_regmap_slave.sv
module twi_regmap_slave #(
    parameter int         BUSY_CYCLES = 50000,
    parameter int         TBL_ROWS    = 64,
    parameter int         PAGE_BITS   = 4,
    parameter logic [7:0] CFG0_RST    = 8'h08,
    parameter logic [7:0] CFG5_RST    = 8'h03
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] dev_sel_i,
    input  logic       wp_n_i,
    output logic       sda_oe_o
);

    logic       sda_s, start_det, stop_det, scl_rise, scl_fall;
    logic       wr_en, wel, busy;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;

    twi_bus_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .sda_o   (sda_s),
        .start_o (start_det),
        .stop_o  (stop_det),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall)
    );

    twi_proto #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .TBL_ROWS    (TBL_ROWS),
        .PAGE_BITS   (PAGE_BITS)
    ) u_proto (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_det),
        .stop_i    (stop_det),
        .rise_i    (scl_rise),
        .fall_i    (scl_fall),
        .sda_i     (sda_s),
        .dev_sel_i (dev_sel_i),
        .wp_n_i    (wp_n_i),
        .wel_i     (wel),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .sda_oe_o  (sda_oe_o),
        .busy_o    (busy)
    );

    twi_regfile #(
        .TBL_ROWS (TBL_ROWS),
        .CFG0_RST (CFG0_RST),
        .CFG5_RST (CFG5_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wel_o     (wel)
    );

endmodule

// File: rtl/twi_regmap_slave_chk.sv
module twi_regmap_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       wp_n,
    input logic       busy,
    input logic       stop_det,
    input logic       wr_en,
    input logic [7:0] wr_addr,
    input logic       wel
);

    // stores other than the latch need the latch set
    assert_store_needs_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 8'h86) |-> wel);

    // protect pin low lets only the latch through
    assert_protect_pin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 8'h86) |-> wp_n);

    // busy window keeps the data line released
    assert_busy_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    // busy window opens only on a detected STOP
    assert_busy_after_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // the slave moves SDA only while the clock line is low
    assert_sda_moves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

endmodule

bind twi_regmap_slave twi_regmap_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe_o),
    .wp_n     (wp_n_i),
    .busy     (busy),
    .stop_det (stop_det),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wel      (wel)
);

// File: tb/twi_regmap_slave_bench.sv
module twi_regmap_slave_bench;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;
    localparam int         BUSY       = 200;
    localparam logic [2:0] DEV        = 3'b101;

    logic clk, rst_n, m_scl, m_sda, wp_n, sda_oe;
    wire  sda_bus = m_sda & ~sda_oe;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] wbuf [32];
    logic       ackv [34];
    logic [7:0] rbuf [64];

    twi_regmap_slave #(.BUSY_CYCLES(BUSY)) u_twi_regmap_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .dev_sel_i (DEV),
        .wp_n_i    (wp_n),
        .sda_oe_o  (sda_oe)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bstart();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bstop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(2 * Q);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        r = sda_bus;  tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = !r;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, r);
            b = {b[6:0], r};
        end
        clk_bit(!give_ack, r);
    endtask

    task automatic wr_txn(input logic [2:0] dev, input logic [7:0] addr, input int n);
        bstart();
        send_byte({4'b1010, dev, 1'b0}, ackv[0]);
        send_byte(addr, ackv[1]);
        for (int i = 0; i < n; i++) send_byte(wbuf[i], ackv[2 + i]);
        bstop();
    endtask

    task automatic rd_txn(input logic [7:0] addr, input int n);
        bstart();
        send_byte({4'b1010, DEV, 1'b0}, ackv[0]);
        send_byte(addr, ackv[1]);
        bstart();
        send_byte({4'b1010, DEV, 1'b1}, ackv[2]);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bstop();
    endtask

    task automatic wr1(input logic [7:0] addr, input logic [7:0] v);
        wbuf[0] = v;
        wr_txn(DEV, addr, 1);
    endtask

    task automatic rd1(input string tag, input logic [7:0] addr, input logic [7:0] exp);
        rd_txn(addr, 1);
        chk8({tag, " addr ack"}, {7'b0, ackv[0] & ackv[1] & ackv[2]}, 8'h01);
        chk8(tag, rbuf[0], exp);
    endtask

    function automatic logic [7:0] pat(input int r);
        return 8'(r * 37 + 5);
    endfunction

    initial begin
        int i;
        logic a;
        logic [7:0] b;
        rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; wp_n = 1'b1;
        tick(5);
        chk8("R10 sda released in reset", {7'b0, sda_oe}, 8'h00);
        rst_n = 1'b1;
        tick(5);

        // R10: reset contents of the control block
        rd_txn(8'h80, 16);
        chk8("R10 read acks", {7'b0, ackv[0] & ackv[1] & ackv[2]}, 8'h01);
        for (int k = 0; k < 16; k++)
            chk8("R10 control reset", rbuf[k], k == 0 ? 8'h08 : (k == 5 ? 8'h03 : 8'h00));
        rd1("R10 table reset", 8'hC7, 8'h00);

        // R1: wrong select bits, wrong type nibble
        bstart();
        send_byte({4'b1010, 3'b100, 1'b0}, a);
        chk8("R1 wrong select nack", {7'b0, a}, 8'h00);
        send_byte(8'h81, a);
        chk8("R1 ignored until START", {7'b0, a}, 8'h00);
        bstop();
        bstart();
        send_byte({4'b1011, DEV, 1'b0}, a);
        chk8("R1 wrong type nack", {7'b0, a}, 8'h00);
        bstop();

        // R2: latch clear refuses data
        wr1(8'h81, 8'h15);
        chk8("R1 own address ack", {7'b0, ackv[0]}, 8'h01);
        chk8("R2 data nack latch clear", {7'b0, ackv[2]}, 8'h00);
        rd1("R2 discarded", 8'h81, 8'h00);

        // R3: latch set, other value ignored
        wr1(8'h86, 8'h80);
        chk8("R3 latch write ack", {7'b0, ackv[2]}, 8'h01);
        rd1("R3 latch set", 8'h86, 8'h80);
        wr1(8'h86, 8'h55);
        chk8("R3 odd value ack", {7'b0, ackv[2]}, 8'h01);
        rd1("R3 odd value keeps latch", 8'h86, 8'h80);

        // R11: volatile multi-byte write, no busy afterwards
        wbuf[0] = 8'hEA; wbuf[1] = 8'h00; wbuf[2] = 8'h5C;
        wr_txn(DEV, 8'h81, 3);
        chk8("R11 volatile acks", {7'b0, ackv[2] & ackv[3] & ackv[4]}, 8'h01);
        rd_txn(8'h81, 3);
        chk8("R11 no busy after volatile", {7'b0, ackv[0]}, 8'h01);
        chk8("R11 sel low six bits", rbuf[0], 8'h2A);
        chk8("R9 0x82 unchanged", rbuf[1], 8'h00);
        chk8("R11 direct byte", rbuf[2], 8'h5C);

        // R4 and R6: single-byte register, then busy window
        wbuf[0] = 8'h09; wbuf[1] = 8'h11;
        wr_txn(DEV, 8'h80, 2);
        chk8("R4 first byte ack", {7'b0, ackv[2]}, 8'h01);
        chk8("R4 second byte nack", {7'b0, ackv[3]}, 8'h00);
        bstart();
        send_byte({4'b1010, DEV, 1'b0}, a);
        chk8("R6 address nack while busy", {7'b0, a}, 8'h00);
        bstop();
        tick(BUSY + 40);
        rd_txn(8'h80, 2);
        chk8("R6 ack after window", {7'b0, ackv[0]}, 8'h01);
        chk8("R4 cfg0 stored", rbuf[0], 8'h09);
        chk8("R4 following byte discarded", rbuf[1], 8'h2A);

        wbuf[0] = 8'h13; wbuf[1] = 8'h77;
        wr_txn(DEV, 8'h85, 2);
        chk8("R4 cfg5 second nack", {7'b0, ackv[3]}, 8'h00);
        tick(BUSY + 40);
        rd1("R4 cfg5 stored", 8'h85, 8'h13);

        wbuf[0] = 8'h80; wbuf[1] = 8'h00;
        wr_txn(DEV, 8'h86, 2);
        chk8("R4 latch second nack", {7'b0, ackv[3]}, 8'h00);
        rd1("R4 latch stays set", 8'h86, 8'h80);

        // R5: page write starting mid-page
        for (int k = 0; k < 12; k++) wbuf[k] = 8'h40 + 8'(k);
        wr_txn(DEV, 8'h9B, 12);
        a = 1'b1;
        for (int k = 0; k < 12; k++) a = a & ackv[2 + k];
        chk8("R5 page acks", {7'b0, a}, 8'h01);
        tick(BUSY + 40);
        rd_txn(8'h90, 16);
        for (int o = 0; o < 16; o++)
            chk8("R5 wrap 12 from 11", rbuf[o],
                 o >= 11 ? 8'h40 + 8'(o - 11) : (o <= 6 ? 8'h45 + 8'(o) : 8'h00));

        // R5: overlong page write
        for (int k = 0; k < 20; k++) wbuf[k] = 8'h80 + 8'(k);
        wr_txn(DEV, 8'hA0, 20);
        tick(BUSY + 40);
        rd_txn(8'hA0, 16);
        for (int o = 0; o < 16; o++)
            chk8("R5 overwrite 20 bytes", rbuf[o], o < 4 ? 8'h90 + 8'(o) : 8'h80 + 8'(o));

        // R5/R8 sweep of every row
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 16; k++) wbuf[k] = pat(16 * p + k);
            wr_txn(DEV, 8'h90 + 8'(16 * p), 16);
            tick(BUSY + 40);
        end
        rd_txn(8'h90, 64);
        for (int r = 0; r < 64; r++) chk8("R8 table sweep", rbuf[r], pat(r));

        // R8: read across the control/table boundary
        rd_txn(8'h8E, 4);
        chk8("R8 cross 8E", rbuf[0], 8'h00);
        chk8("R8 cross 8F", rbuf[1], 8'h00);
        chk8("R8 cross 90", rbuf[2], pat(0));
        chk8("R8 cross 91", rbuf[3], pat(1));

        // R8: master NACK ends transmission
        bstart();
        send_byte({4'b1010, DEV, 1'b0}, a);
        send_byte(8'h92, a);
        bstart();
        send_byte({4'b1010, DEV, 1'b1}, a);
        recv_byte(1'b0, b);
        chk8("R8 byte before nack", b, pat(2));
        recv_byte(1'b0, b);
        chk8("R8 released after nack", b, 8'hFF);
        bstop();

        // R7: protect pin
        wp_n = 1'b0;
        tick(4);
        wr1(8'h83, 8'h99);
        chk8("R7 control nack", {7'b0, ackv[2]}, 8'h00);
        wr1(8'h95, 8'h11);
        chk8("R7 table nack", {7'b0, ackv[2]}, 8'h00);
        rd1("R7 control unchanged", 8'h83, 8'h5C);
        rd1("R7 table unchanged", 8'h95, pat(5));
        wr1(8'h86, 8'h00);
        chk8("R7 latch still writable", {7'b0, ackv[2]}, 8'h01);
        rd1("R3 latch cleared", 8'h86, 8'h00);
        wp_n = 1'b1;
        tick(4);
        wr1(8'h83, 8'h77);
        chk8("R2 nack after clear", {7'b0, ackv[2]}, 8'h00);
        wr1(8'h86, 8'h80);

        // R9: reserved and unmapped locations
        wr1(8'h82, 8'hAB);
        chk8("R9 reserved ack", {7'b0, ackv[2]}, 8'h01);
        wr1(8'h84, 8'hCD);
        wr1(8'h87, 8'hEE);
        wr1(8'h8C, 8'h3C);
        rd_txn(8'h82, 11);
        for (int k = 0; k < 11; k++)
            chk8("R9 reserved read", rbuf[k],
                 k == 1 ? 8'h5C : (k == 3 ? 8'h13 : (k == 4 ? 8'h80 : 8'h00)));
        wr1(8'h10, 8'h42);
        chk8("R9 unmapped write ack", {7'b0, ackv[2]}, 8'h01);
        rd1("R9 R11 low unmapped", 8'h10, 8'hFF);
        rd1("R9 high unmapped", 8'hD0, 8'hFF);

        i = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        tick(190000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule